// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits behind the bus-cycle capture logic of a NOR flash array. It observes one write cycle per `wr_valid` pulse, each carrying an address and a data word. It recognises the multi-cycle command language that the array accepts. Most commands must begin with a two-write unlock key. A bypass context lets program commands skip that key. Erase commands need a second key before the confirm, and a timed window allows more blocks of the same bank to be added to the erase.

The sequencer performs no array access itself. Each accepted operation is reported as one registered strobe on `op_valid`, with an operation code, an address and one or two data words. A separate program/erase engine consumes these strobes and signals completion on `eng_done`. The read path uses `rd_mode` to select array data, identifier data, query data or status. The power-down enable taken from a configuration command is held on `cfg_pd`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block presents `rd_mode` = 0 (array) and `op_valid` = 0. It also clears `cfg_pd`. Mode encoding: 0 array, 1 identifier, 2 query, 3 status.
- R2: The unlock key is AAh written at low address 555h, followed by 55h at 2AAh. The key followed by 90h at 555h selects mode 1. The write 98h at low address 055h selects mode 2, with or without the key. F0h, with or without the key, selects mode 0.
- R3: The key, then A0h at 555h, then one data write produces one strobe with `op_code` = 1 in the cycle after that write. The strobe carries the write's address and data. `rd_mode` is 3 until `eng_done`, and then returns to 0.
- R4: The key, then 40h at 555h, then two data writes produce `op_code` = 2, provided the two addresses differ in bit 0 and nowhere else. The strobe carries the first address, the first data word in `op_data` and the second in `op_data2`. Any other address pair gives no strobe and mode 0.
- R5: The key, then 60h at 555h, then 03h at any address loads `cfg_pd` from address bit 10 of the 03h write.
- R6: The key followed by 20h at 555h enters bypass. In bypass, A0h at any address followed by a data write gives `op_code` = 1, and 40h followed by two data writes gives `op_code` = 2. After the program completes, the block stays in bypass. The write pair 90h then 00h leaves bypass.
- R7: Block erase is the key, 80h at 555h, the key again, then 30h at the block address. This gives `op_code` = 3 and mode 3. Further 30h writes in the window give another code-3 strobe each and restart the window. After ERASE_TMO_CYC cycles with no confirm, `op_code` = 5 (start) is issued.
- R8: The bank is address bit ADDR_W-1. A confirm from the other bank during the window gives `op_code` = 6 (abort) and mode 0. F0h during the window does the same.
- R9: The same erase prefix ending in 10h gives `op_code` = 4 with the written address, and mode 3.
- R10: During a running block erase, B0h at any address gives `op_code` = 7 and mode 0. While suspended, only two commands are accepted: 30h, which gives `op_code` = 8 and mode 3, and a keyed program. Bank erase cannot be suspended.
- R11: A cycle that breaks or does not fit a sequence yields no strobe and returns to mode 0, leaving bypass if it was active.
- R12: While a program or an erase is running, every write is ignored except B0h to a running block erase. No strobe results, and the mode holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One captured bus write this cycle |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data of the write |
| eng_done | input | 1 | Engine finished the current program or erase |
| rd_mode | output | 2 | Read source select |
| op_valid | output | 1 | Operation strobe |
| op_code | output | 4 | Operation code |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | DATA_W | First data word |
| op_data2 | output | DATA_W | Second data word (double-word program) |
| cfg_pd | output | 1 | Power-down enable from configuration |

## Verification
The properties assume two things about the inputs. `wr_valid` is low throughout reset. `eng_done` arrives only after the engine has received an operation. The bank property also relies on the engine never starting an erase group except through this block. The stimulus respects these assumptions. It holds `wr_valid` low during reset and pulses `eng_done` only after a program, double-word or erase strobe. It leaves at least one idle cycle between writes, so the erase window counts down only through cycles that the bench can account for.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_ID     = 2'd1,
    MODE_CFI    = 2'd2,
    MODE_STATUS = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_PROG        = 4'd1,
    OP_DPROG       = 4'd2,
    OP_ERASE_BLK   = 4'd3,
    OP_ERASE_BANK  = 4'd4,
    OP_ERASE_GO    = 4'd5,
    OP_ERASE_ABORT = 4'd6,
    OP_SUSPEND     = 4'd7,
    OP_RESUME      = 4'd8
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_SETUP, S_CFG, S_PDATA, S_DW1, S_DW2, S_EUL1,
    S_EUL2, S_ECONF, S_ETMO, S_ERASING, S_SUSP, S_RUN, S_BYP, S_BYPX
  } seq_st_e;

  typedef struct packed {
    logic       ul1;
    logic       ul2;
    logic       at_key;
    logic       at_cfi;
    logic [7:0] cmd;
  } wr_class_t;

  localparam logic [7:0] C_UL1   = 8'hAA;
  localparam logic [7:0] C_UL2   = 8'h55;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_CFI   = 8'h98;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_CFG   = 8'h60;
  localparam logic [7:0] C_CFGOK = 8'h03;
  localparam logic [7:0] C_BYP   = 8'h20;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_DPROG = 8'h40;
  localparam logic [7:0] C_ESET  = 8'h80;
  localparam logic [7:0] C_EBLK  = 8'h30;
  localparam logic [7:0] C_EBANK = 8'h10;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_BYPX  = 8'h00;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int KEY_AW = 11
) (
  input  logic [KEY_AW-1:0] key_addr,
  input  logic [7:0]        cmd_byte,
  output wr_class_t         cls
);
  localparam logic [KEY_AW-1:0] KEY_A1  = KEY_AW'(12'h555);
  localparam logic [KEY_AW-1:0] KEY_A2  = KEY_AW'(12'h2AA);
  localparam logic [KEY_AW-1:0] CFI_ADR = KEY_AW'(12'h055);

  always_comb begin
    cls.cmd    = cmd_byte;
    cls.at_key = (key_addr == KEY_A1);
    cls.at_cfi = (key_addr == CFI_ADR);
    cls.ul1    = (key_addr == KEY_A1) && (cmd_byte == C_UL1);
    cls.ul2    = (key_addr == KEY_A2) && (cmd_byte == C_UL2);
  end
endmodule

// File: rtl/flash_erase_tmo.sv
module flash_erase_tmo #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int KEY_AW        = 11,
  parameter int CFG_BIT       = 10,
  parameter int ERASE_TMO_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_done,
  output logic [1:0]        rd_mode,
  output logic              op_valid,
  output logic [3:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] op_data2,
  output logic              cfg_pd
);
  localparam int BANK_BIT = ADDR_W - 1;

  wr_class_t         cls;
  seq_st_e           st, st_n;
  rd_mode_e          mode, mode_n;
  op_e               opc, opc_n;
  logic              opv, opv_n;
  logic [ADDR_W-1:0] opa, opa_n, dwa, dwa_n;
  logic [DATA_W-1:0] opd, opd_n, opd2, opd2_n, dwd, dwd_n;
  logic              byp, byp_n, sus, sus_n, blk, blk_n, ebank, ebank_n;
  logic              cfg, cfg_n;
  logic              bad, tmo_restart, tmo_exp;

  flash_cmd_decode #(.KEY_AW(KEY_AW)) u_dec (
    .key_addr (wr_addr[KEY_AW-1:0]),
    .cmd_byte (wr_data[7:0]),
    .cls      (cls)
  );

  flash_erase_tmo #(.LIMIT(ERASE_TMO_CYC)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .run     (st == S_ETMO),
    .restart (tmo_restart),
    .expired (tmo_exp)
  );

  always_comb begin
    st_n = st;  mode_n = mode;  byp_n = byp;  sus_n = sus;
    blk_n = blk;  ebank_n = ebank;  dwa_n = dwa;  dwd_n = dwd;
    cfg_n = cfg;  opv_n = 1'b0;  opc_n = OP_NONE;
    opa_n = opa;  opd_n = opd;  opd2_n = opd2;
    bad = 1'b0;  tmo_restart = 1'b0;
    case (st)
      S_IDLE: if (wr_valid) begin
        if (cls.ul1)                            st_n = S_UL1;
        else if (cls.cmd == C_RESET)            mode_n = MODE_ARRAY;
        else if (cls.cmd == C_CFI && cls.at_cfi) mode_n = MODE_CFI;
        else                                    bad = 1'b1;
      end
      S_UL1: if (wr_valid) begin
        if (cls.ul2) st_n = S_SETUP;
        else         bad = 1'b1;
      end
      S_SETUP: if (wr_valid) begin
        if (sus) begin
          if (cls.at_key && cls.cmd == C_PROG) st_n = S_PDATA;
          else                                 bad = 1'b1;
        end else if (cls.at_key && cls.cmd == C_ID) begin
          mode_n = MODE_ID;  st_n = S_IDLE;
        end else if (cls.at_cfi && cls.cmd == C_CFI) begin
          mode_n = MODE_CFI;  st_n = S_IDLE;
        end else if (cls.cmd == C_RESET) begin
          mode_n = MODE_ARRAY;  st_n = S_IDLE;
        end else if (cls.at_key && cls.cmd == C_CFG)   st_n = S_CFG;
        else if (cls.at_key && cls.cmd == C_BYP) begin
          byp_n = 1'b1;  mode_n = MODE_ARRAY;  st_n = S_BYP;
        end else if (cls.at_key && cls.cmd == C_PROG)  st_n = S_PDATA;
        else if (cls.at_key && cls.cmd == C_DPROG) st_n = S_DW1;
        else if (cls.at_key && cls.cmd == C_ESET)  st_n = S_EUL1;
        else bad = 1'b1;
      end
      S_CFG: if (wr_valid) begin
        if (cls.cmd == C_CFGOK) begin
          cfg_n = wr_addr[CFG_BIT];  mode_n = MODE_ARRAY;  st_n = S_IDLE;
        end else bad = 1'b1;
      end
      S_PDATA: if (wr_valid) begin
        opv_n = 1'b1;  opc_n = OP_PROG;  opa_n = wr_addr;  opd_n = wr_data;
        mode_n = MODE_STATUS;  st_n = S_RUN;
      end
      S_DW1: if (wr_valid) begin
        dwa_n = wr_addr;  dwd_n = wr_data;  st_n = S_DW2;
      end
      S_DW2: if (wr_valid) begin
        if (wr_addr[ADDR_W-1:1] == dwa[ADDR_W-1:1] && wr_addr[0] != dwa[0]) begin
          opv_n = 1'b1;  opc_n = OP_DPROG;  opa_n = dwa;  opd_n = dwd;
          opd2_n = wr_data;  mode_n = MODE_STATUS;  st_n = S_RUN;
        end else bad = 1'b1;
      end
      S_EUL1: if (wr_valid) begin
        if (cls.ul1) st_n = S_EUL2;
        else         bad = 1'b1;
      end
      S_EUL2: if (wr_valid) begin
        if (cls.ul2) st_n = S_ECONF;
        else         bad = 1'b1;
      end
      S_ECONF: if (wr_valid) begin
        if (cls.cmd == C_EBLK) begin
          opv_n = 1'b1;  opc_n = OP_ERASE_BLK;  opa_n = wr_addr;
          ebank_n = wr_addr[BANK_BIT];  blk_n = 1'b1;
          mode_n = MODE_STATUS;  st_n = S_ETMO;
        end else if (cls.cmd == C_EBANK) begin
          opv_n = 1'b1;  opc_n = OP_ERASE_BANK;  opa_n = wr_addr;
          blk_n = 1'b0;  mode_n = MODE_STATUS;  st_n = S_ERASING;
        end else bad = 1'b1;
      end
      S_ETMO: begin
        if (wr_valid && cls.cmd == C_EBLK && wr_addr[BANK_BIT] == ebank) begin
          opv_n = 1'b1;  opc_n = OP_ERASE_BLK;  opa_n = wr_addr;
          tmo_restart = 1'b1;
        end else if (wr_valid && (cls.cmd == C_EBLK || cls.cmd == C_RESET)) begin
          opv_n = 1'b1;  opc_n = OP_ERASE_ABORT;  opa_n = wr_addr;
          mode_n = MODE_ARRAY;  st_n = S_IDLE;
        end else if (tmo_exp) begin
          opv_n = 1'b1;  opc_n = OP_ERASE_GO;  st_n = S_ERASING;
        end
      end
      S_ERASING: begin
        if (eng_done) begin
          mode_n = MODE_ARRAY;  blk_n = 1'b0;  st_n = S_IDLE;
        end else if (wr_valid && blk && cls.cmd == C_SUSP) begin
          opv_n = 1'b1;  opc_n = OP_SUSPEND;  opa_n = wr_addr;
          sus_n = 1'b1;  mode_n = MODE_ARRAY;  st_n = S_SUSP;
        end
      end
      S_SUSP: if (wr_valid) begin
        if (cls.cmd == C_EBLK) begin
          opv_n = 1'b1;  opc_n = OP_RESUME;  opa_n = wr_addr;
          sus_n = 1'b0;  mode_n = MODE_STATUS;  st_n = S_ERASING;
        end else if (cls.ul1) st_n = S_UL1;
      end
      S_RUN: if (eng_done) begin
        mode_n = MODE_ARRAY;
        st_n   = byp ? S_BYP : (sus ? S_SUSP : S_IDLE);
      end
      S_BYP: if (wr_valid) begin
        if (cls.cmd == C_PROG)       st_n = S_PDATA;
        else if (cls.cmd == C_DPROG) st_n = S_DW1;
        else if (cls.cmd == C_ID)    st_n = S_BYPX;
        else                         bad = 1'b1;
      end
      S_BYPX: if (wr_valid) begin
        if (cls.cmd == C_BYPX) begin
          byp_n = 1'b0;  mode_n = MODE_ARRAY;  st_n = S_IDLE;
        end else bad = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
    if (bad) begin
      byp_n  = 1'b0;
      mode_n = MODE_ARRAY;
      st_n   = sus ? S_SUSP : S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;  mode <= MODE_ARRAY;  opv <= 1'b0;  opc <= OP_NONE;
      opa <= '0;  opd <= '0;  opd2 <= '0;  dwa <= '0;  dwd <= '0;
      byp <= 1'b0;  sus <= 1'b0;  blk <= 1'b0;  ebank <= 1'b0;  cfg <= 1'b0;
    end else begin
      st <= st_n;  mode <= mode_n;  opv <= opv_n;  opc <= opc_n;
      opa <= opa_n;  opd <= opd_n;  opd2 <= opd2_n;  dwa <= dwa_n;  dwd <= dwd_n;
      byp <= byp_n;  sus <= sus_n;  blk <= blk_n;  ebank <= ebank_n;  cfg <= cfg_n;
    end
  end

  assign rd_mode  = mode;
  assign op_valid = opv;
  assign op_code  = opc;
  assign op_addr  = opa;
  assign op_data  = opd;
  assign op_data2 = opd2;
  assign cfg_pd   = cfg;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic [1:0] rd_mode,
  input logic       op_valid,
  input logic [3:0] op_code,
  input logic       op_bank,
  input logic       cfg_pd
);
  logic grp_open, grp_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_open <= 1'b0;  grp_bank <= 1'b0;
    end else if (op_valid) begin
      if (op_code == OP_ERASE_BLK) begin
        grp_open <= 1'b1;  grp_bank <= op_bank;
      end else if (op_code == OP_ERASE_GO || op_code == OP_ERASE_ABORT) begin
        grp_open <= 1'b0;
      end
    end
  end

  AST_OP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code != OP_ERASE_GO) |-> $past(wr_valid)); // R12
  AST_CFG_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_pd) |-> $past(wr_valid)); // R5
  AST_PROG_STATUS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_PROG || op_code == OP_DPROG)) |-> rd_mode == MODE_STATUS); // R3
  AST_SUSPEND_ARRAY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SUSPEND) |-> rd_mode == MODE_ARRAY); // R10
  AST_ERASE_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ERASE_BLK && grp_open) |-> op_bank == grp_bank); // R8
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .rd_mode  (rd_mode),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_bank  (op_addr[ADDR_W-1]),
  .cfg_pd   (cfg_pd)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 19;
  localparam int DW  = 16;
  localparam int TMO = 12;

  localparam int K_PROG = 1, K_DPROG = 2, K_BLK = 3, K_BANK = 4, K_GO = 5,
                 K_ABORT = 6, K_SUSP = 7, K_RES = 8;

  logic clk = 1'b0, rst = 1'b1, wr_valid = 1'b0, eng_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] rd_mode;
  logic op_valid, cfg_pd;
  logic [3:0] op_code;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, op_data2;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct {
    int code; int addr; int d; int d2; bit full; string req;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .ERASE_TMO_CYC(TMO)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .eng_done(eng_done), .rd_mode(rd_mode),
    .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
    .op_data(op_data), .op_data2(op_data2), .cfg_pd(cfg_pd)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input string req, input int code, input int a, input int d,
                      input int d2, input bit full);
    exp_t e;
    e.code = code; e.addr = a; e.d = d; e.d2 = d2; e.full = full; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares every strobe against the scoreboard
  always @(negedge clk) begin
    if (!rst && op_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: actual unexpected op %0d expected none", op_code);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.req, " code"}, int'(op_code), e.code);
        if (e.full) begin
          check({e.req, " addr"}, int'(op_addr), e.addr);
          if (e.code == K_PROG || e.code == K_DPROG) check({e.req, " data"}, int'(op_data), e.d);
          if (e.code == K_DPROG) check({e.req, " data2"}, int'(op_data2), e.d2);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock;
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  task automatic done_pulse;
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic erase_blk(input int a);
    unlock; wr('h555, 'h80); unlock; wr(a, 'h30);
  endtask

  task automatic drain(input string req);
    repeat (2) @(negedge clk);
    check({req, " scoreboard empty"}, q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", rd_mode, 0);
    check("R1 op_valid", op_valid, 0);
    check("R1 cfg_pd", cfg_pd, 0);

    // R2 identifier, query, reset
    unlock; wr('h555, 'h90);  check("R2 id mode", rd_mode, 1);
    wr('h0, 'hF0);            check("R2 bare reset", rd_mode, 0);
    wr('h55, 'h98);           check("R2 bare query", rd_mode, 2);
    unlock; wr('h0, 'hF0);    check("R2 keyed reset", rd_mode, 0);
    unlock; wr('h55, 'h98);   check("R2 keyed query", rd_mode, 2);
    wr('h0, 'hF0);

    // R3 program, R12 ignore while running
    unlock; wr('h555, 'hA0);
    push("R3", K_PROG, 'h12345, 'hBEEF, 0, 1);
    wr('h12345, 'hBEEF);      check("R3 status mode", rd_mode, 3);
    wr('h555, 'hAA); wr('h0, 'hF0);
    check("R12 busy mode held", rd_mode, 3);
    done_pulse;               check("R3 done mode", rd_mode, 0);
    drain("R3");

    // R5 configuration
    unlock; wr('h555, 'h60); wr('h00400, 'h03); check("R5 pd set", cfg_pd, 1);
    unlock; wr('h555, 'h60); wr('h00000, 'h03); check("R5 pd clear", cfg_pd, 0);

    // R4 double word, good and bad pair
    unlock; wr('h555, 'h40); wr('h20010, 'h1111);
    push("R4", K_DPROG, 'h20010, 'h1111, 'h2222, 1);
    wr('h20011, 'h2222);      check("R4 status", rd_mode, 3);
    done_pulse;
    unlock; wr('h555, 'h40); wr('h20010, 'h3333); wr('h20013, 'h4444);
    check("R4 bad pair mode", rd_mode, 0);
    unlock; wr('h555, 'h90);  check("R4 recovered", rd_mode, 1);
    wr('h0, 'hF0);
    drain("R4");

    // R6 bypass
    unlock; wr('h555, 'h20);
    wr('h777, 'hA0);
    push("R6", K_PROG, 'h300, 'h0F0F, 0, 1);
    wr('h300, 'h0F0F);        done_pulse;
    wr('h1, 'h40); wr('h100, 'h0001);
    push("R6", K_DPROG, 'h100, 'h0001, 'h0002, 1);
    wr('h101, 'h0002);        done_pulse;
    wr('h0, 'h90); wr('h0, 'h00);
    wr('h0, 'hA0); wr('h300, 'h0005);
    check("R6 exited mode", rd_mode, 0);
    drain("R6");

    // R11 broken sequences
    wr('h555, 'hAA); wr('h555, 'h55); wr('h555, 'h90);
    check("R11 broken key", rd_mode, 0);
    unlock; wr('h555, 'h90); wr('h123, 'h77);
    check("R11 stray write", rd_mode, 0);
    drain("R11");

    // R7 block erase with extra block and window timing
    push("R7", K_BLK, 'h10000, 0, 0, 1);
    erase_blk('h10000);       check("R7 status", rd_mode, 3);
    push("R7", K_BLK, 'h18000, 0, 0, 1);
    push("R7", K_GO, 0, 0, 0, 0);
    wr('h18000, 'h30);
    repeat (TMO - 1) @(negedge clk);
    check("R7 no start yet", op_valid, 0);
    @(negedge clk);
    check("R7 start strobe", op_valid, 1);
    // R10 suspend, program while suspended, resume
    push("R10", K_SUSP, 0, 0, 0, 0);
    wr('h0, 'hB0);            check("R10 suspend mode", rd_mode, 0);
    wr('h0, 'hF0); wr('h555, 'h90);
    check("R10 ignored in suspend", rd_mode, 0);
    unlock; wr('h555, 'hA0);
    push("R10", K_PROG, 'h30000, 'h00FF, 0, 1);
    wr('h30000, 'h00FF);      check("R10 prog status", rd_mode, 3);
    done_pulse;               check("R10 back suspended", rd_mode, 0);
    push("R10", K_RES, 'h10000, 0, 0, 1);
    wr('h10000, 'h30);        check("R10 resume status", rd_mode, 3);
    done_pulse;               check("R10 erase done", rd_mode, 0);
    drain("R10");

    // R8 other bank aborts, reset in window aborts
    push("R8", K_BLK, 'h10000, 0, 0, 1);
    erase_blk('h10000);
    push("R8", K_ABORT, 0, 0, 0, 0);
    wr('h40000, 'h30);        check("R8 bank abort mode", rd_mode, 0);
    push("R8", K_BLK, 'h20000, 0, 0, 1);
    erase_blk('h20000);
    push("R8", K_ABORT, 0, 0, 0, 0);
    wr('h0, 'hF0);            check("R8 reset abort mode", rd_mode, 0);
    drain("R8");

    // R9 bank erase, not suspendable
    unlock; wr('h555, 'h80); unlock;
    push("R9", K_BANK, 'h40000, 0, 0, 1);
    wr('h40000, 'h10);        check("R9 status", rd_mode, 3);
    wr('h0, 'hB0);            check("R10 bank erase no suspend", rd_mode, 3);
    done_pulse;               check("R9 done", rd_mode, 0);
    drain("R9");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule